// File: doc/BRIEF.md
# Timed Power-Good Output Sequencer

This block brings up the power-good outputs of a card in a fixed order. Each output enables one downstream DC/DC converter. The first output comes on as soon as the gate controller reports that the pass transistor is fully enhanced and the drain of that transistor is seen low. Each later output follows its predecessor after a programmable number of clock cycles. A later output is also held off by its own active-high enable input, so system logic can delay dependent converters until its own conditions are met.

The outputs are active-low open-drain pins with no pull-up. They are modelled here as pull-down enables: a bit at 1 means the pin is driven low (power good asserted), and a bit at 0 means the pin floats. The pad cell itself lies outside this block. Dropping an enable, the permit or the drain-low flag releases the affected outputs in the same cycle, with no clock edge needed. The timers of the released stages then restart from zero.

Top module: `pg_sequencer`

## Requirements
- R1: Encoding: `pg_pull[i]` = 1 means output i is driven low (asserted), and 0 means it floats. `pg_pull[0]` is 1 in the same cycle in which `permit` and `drain_low` are both 1 and `rst` is 0, with no clock edge needed.
- R2: `pg_pull[1]` becomes 1 right after the DELAY_CYC-th rising edge at which `pg_pull[0]` and `stage_en[0]` were both 1 without a break.
- R3: `pg_pull[2]` becomes 1 right after the DELAY_CYC-th rising edge at which `pg_pull[1]` and `stage_en[1]` were both 1 without a break.
- R4: While `stage_en[0]` is 0, `pg_pull[1]` and `pg_pull[2]` are 0, already in the cycle in which it falls.
- R5: While `stage_en[1]` is 0, `pg_pull[2]` is 0 immediately, and `pg_pull[1]` and `pg_pull[0]` are unaffected.
- R6: When `permit` or `drain_low` falls, all three outputs go to 0 in the same cycle. When the condition returns, every later stage again needs its full delay.
- R7: While `rst` (synchronous, active high) is 1, all outputs are 0 and every stage timer is cleared.
- R8: If a stage's enable is 0 when its predecessor becomes active, the delay does not start until the enable rises. The delay is then counted from the first edge that sees the enable high.
- R9: A stage's timer restarts from zero whenever its enable or its predecessor drops, even for one cycle, in the middle of the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; releases all outputs |
| permit | input | 1 | Gate controller reports full enhancement of the pass transistor |
| drain_low | input | 1 | Drain of the pass transistor is below its threshold |
| stage_en | input | NUM_STAGES-1 | Bit i-1 enables stage i (active high) |
| pg_pull | output | NUM_STAGES | Bit i = 1: power-good i driven low; 0: floating |

## Verification
The hardest states to reach are a stage timer cut off one cycle before it expires, and an enable that rises long after its predecessor became active. Both are driven directly. The enable is toggled for exactly one cycle at delay-minus-one, and an enable is held low through a long settled period before it is raised. A behavioural model that counts consecutive qualifying cycles for each stage is compared with the outputs every cycle. Directed checks sample the outputs one cycle before and at the edge where each delay completes.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    // Drive state of one open-drain power-good pad
    typedef enum logic {
        PAD_FLOAT = 1'b0,
        PAD_PULL  = 1'b1
    } pad_drive_e;

    // Status carried from a stage timer to the output logic
    typedef struct packed {
        logic armed;    // predecessor active and own enable high
        logic expired;  // delay fully counted
    } stage_stat_t;

    // Width of a counter that must reach value d
    function automatic int unsigned cnt_width(input int unsigned d);
        return (d < 2) ? 1 : $clog2(d + 1);
    endfunction

    // Combine a stage status into a pad drive
    function automatic pad_drive_e stage_drive(input stage_stat_t s);
        return (s.armed && s.expired) ? PAD_PULL : PAD_FLOAT;
    endfunction

endpackage

// File: rtl/pgs_root.sv
module pgs_root
    import pgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       permit,
    input  logic       drain_low,
    output pad_drive_e root_drive
);

    always_comb begin
        root_drive = PAD_FLOAT;
        if (!rst && permit && drain_low)
            root_drive = PAD_PULL;
    end

    // R6: losing the drain-low flag means the first output is floating
    p_root_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (!drain_low || !permit) |-> (root_drive == PAD_FLOAT));

    // R1: both qualifiers present means the first output pulls low
    p_root_pulls_r1: assert property (@(posedge clk) disable iff (rst)
        (permit && drain_low) |-> (root_drive == PAD_PULL));

endmodule

// File: rtl/pgs_stage_timer.sv
module pgs_stage_timer
    import pgs_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        armed,
    output stage_stat_t stat
);

    localparam int unsigned CNT_W = cnt_width(DELAY_CYC);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !armed)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        stat.armed   = armed;
        stat.expired = (cnt_q == LIMIT);
    end

    // R2: the counter never passes the programmed delay
    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R9: a break in the arming condition restarts the count
    p_cnt_restart_r9: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (cnt_q == '0));

    // R8: expiry is only ever reached while armed on the previous edge
    p_expiry_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.expired) |-> $past(armed));

endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
    import pgs_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 3,
    parameter int unsigned DELAY_CYC  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  permit,
    input  logic                  drain_low,
    input  logic [NUM_STAGES-2:0] stage_en,
    output logic [NUM_STAGES-1:0] pg_pull
);

    pad_drive_e drive [NUM_STAGES];

    pgs_root u_root (
        .clk        (clk),
        .rst        (rst),
        .permit     (permit),
        .drain_low  (drain_low),
        .root_drive (drive[0])
    );

    for (genvar g = 1; g < NUM_STAGES; g++) begin : g_stage
        logic        armed;
        stage_stat_t stat;

        assign armed = (drive[g-1] == PAD_PULL) && stage_en[g-1];

        pgs_stage_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
            .clk   (clk),
            .rst   (rst),
            .armed (armed),
            .stat  (stat)
        );

        assign drive[g] = stage_drive(stat);
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_out
        assign pg_pull[g] = (drive[g] == PAD_PULL);
    end

    // R7: reset holds every output floating
    p_reset_release_r7: assert property (@(posedge clk)
        rst |-> (pg_pull == '0));

    // R4: first enable low floats all stages beyond the first
    p_en0_releases_r4: assert property (@(posedge clk) disable iff (rst)
        !stage_en[0] |-> (pg_pull[NUM_STAGES-1:1] == '0));

    // R3: an output is only asserted while its predecessor is asserted
    p_chain_order_r3: assert property (@(posedge clk) disable iff (rst)
        (pg_pull[NUM_STAGES-1:1] & ~pg_pull[NUM_STAGES-2:0]) == '0);

    // R5: releasing the last enable does not disturb the earlier outputs
    p_en_last_local_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(stage_en[NUM_STAGES-2]) && $stable(stage_en[NUM_STAGES-3:0])
         && $stable(permit) && $stable(drain_low))
        |-> $stable(pg_pull[NUM_STAGES-2:0]));

endmodule

// File: tb/pg_sequencer_test.sv
module pg_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       permit = 1'b0;
    logic       drain_low = 1'b0;
    logic [1:0] stage_en = 2'b00;
    logic [2:0] pg_pull;

    int checks = 0;
    int errors = 0;
    int mcnt [3] = '{0, 0, 0};
    bit done = 0;

    pg_sequencer #(.NUM_STAGES(3), .DELAY_CYC(D)) uut (
        .clk       (clk),
        .rst       (rst),
        .permit    (permit),
        .drain_low (drain_low),
        .stage_en  (stage_en),
        .pg_pull   (pg_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pg_pull=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Behavioural reference: consecutive qualifying cycles per stage
    always @(negedge clk) begin
        logic e0, e1, e2;
        e0 = permit && drain_low && !rst;
        e1 = e0 && stage_en[0] && (mcnt[1] >= D);
        e2 = e1 && stage_en[1] && (mcnt[2] >= D);
        if (!done) begin
            checks++;
            if (pg_pull[0] !== e0) begin
                errors++;
                $display("FAIL R1: pg_pull[0]=%b expected %b at %0t", pg_pull[0], e0, $time);
            end
            checks++;
            if (pg_pull[1] !== e1) begin
                errors++;
                $display("FAIL R2: pg_pull[1]=%b expected %b at %0t", pg_pull[1], e1, $time);
            end
            checks++;
            if (pg_pull[2] !== e2) begin
                errors++;
                $display("FAIL R3: pg_pull[2]=%b expected %b at %0t", pg_pull[2], e2, $time);
            end
        end
        mcnt[1] = (rst || !(e0 && stage_en[0])) ? 0 : ((mcnt[1] < D) ? mcnt[1] + 1 : D);
        mcnt[2] = (rst || !(e1 && stage_en[1])) ? 0 : ((mcnt[2] < D) ? mcnt[2] + 1 : D);
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, pg_pull=%b expected end of test", pg_pull);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset holds everything released even with qualifiers present
        permit = 1; drain_low = 1; stage_en = 2'b11;
        step(3);
        check("R7", pg_pull, 3'b000);

        // R1: leaving reset asserts first output; R2/R3 cascade timing
        rst = 0;
        #1 check("R1", pg_pull, 3'b001);
        step(D - 1);
        check("R2", pg_pull, 3'b001);
        step(1);
        check("R2", pg_pull, 3'b011);
        step(D - 1);
        check("R3", pg_pull, 3'b011);
        step(1);
        check("R3", pg_pull, 3'b111);

        // R5: dropping the last enable floats only the last output
        stage_en[1] = 0;
        #1 check("R5", pg_pull, 3'b011);
        step(2);
        stage_en[1] = 1;
        step(D);
        check("R3", pg_pull, 3'b111);

        // R4: dropping the first enable floats the two later outputs at once
        stage_en[0] = 0;
        #1 check("R4", pg_pull, 3'b001);
        step(3);
        check("R4", pg_pull, 3'b001);

        // R9: one-cycle glitch just before expiry restarts the count
        stage_en[0] = 1;
        step(D - 1);
        stage_en[0] = 0;
        step(1);
        stage_en[0] = 1;
        step(D - 1);
        check("R9", pg_pull, 3'b001);
        step(1);
        check("R9", pg_pull, 3'b011);
        step(D);
        check("R3", pg_pull, 3'b111);

        // R6: losing drain-low releases all, full delays on return
        drain_low = 0;
        #1 check("R6", pg_pull, 3'b000);
        step(2);
        drain_low = 1;
        #1 check("R6", pg_pull, 3'b001);
        step(D - 1);
        check("R6", pg_pull, 3'b001);
        step(1);
        check("R6", pg_pull, 3'b011);
        step(D);
        check("R6", pg_pull, 3'b111);

        // R6: losing permit also releases all
        permit = 0;
        #1 check("R6", pg_pull, 3'b000);

        // R8: enable low while predecessor settles, delay starts on its rise
        stage_en = 2'b00;
        step(2);
        permit = 1;
        step(3 * D);
        check("R8", pg_pull, 3'b001);
        stage_en[0] = 1;
        step(D - 1);
        check("R8", pg_pull, 3'b001);
        step(1);
        check("R8", pg_pull, 3'b011);
        step(2 * D);
        check("R8", pg_pull, 3'b011);
        stage_en[1] = 1;
        step(D - 1);
        check("R8", pg_pull, 3'b011);
        step(1);
        check("R8", pg_pull, 3'b111);

        // R7: reset in mid operation releases and clears timers
        rst = 1;
        step(1);
        check("R7", pg_pull, 3'b000);
        rst = 0;
        #1 check("R7", pg_pull, 3'b001);
        step(D);
        check("R7", pg_pull, 3'b011);
        step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule